// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the command layer of a serial-interface byte memory. A neighbouring shifter delivers whole receive bytes, most significant bit first, together with a synchronous active-low select. It also raises a flag when the select is released while a byte is still half shifted. The engine interprets the first byte of each selected frame as an instruction. For memory access it then collects a two-byte address. After that it either streams array bytes back to the shifter or gathers write bytes into a one-page holding buffer.

When the select is released cleanly after at least one complete write byte, the engine starts a self-timed programming cycle. The cycle first copies only the buffer slots that were filled into the array. It then holds a busy flag for a fixed settle time. The array itself is outside the block, on a simple read/write port. The block also keeps a write-enable latch and three configuration bits: a protection-pin enable and two block-protect bits. A protection neighbour reads those bits and uses them.

Top module: `spi_mem_cmd_engine`

## Requirements
- R1: An instruction byte is valid only when bits 7..4 are zero. Bit 3 is ignored, and bits 2..0 select the command: 110 latch set, 100 latch clear, 101 status read, 001 status write, 011 array read, 010 array write. Any other byte makes the engine ignore the rest of the frame and keep `tx_oe` low until the next select fall.
- R2: The latch-set command sets the write-enable latch, and the latch-clear command clears it. The latch is visible in status bit 1.
- R3: A status read drives `tx_oe` high and presents {enable bit at 7, zeros at 6..4, protect bits at 3..2, latch at 1, busy at 0}. While a programming cycle runs, it presents 8'hFF instead.
- R4: An array read takes a high then a low address byte. Address bits above ADDR_W are ignored. The read presents the addressed byte at once, advances the address by one per further received byte, and wraps from the top address to zero.
- R5: An array write issued while the latch is clear changes no array byte and starts no cycle.
- R6: During a write, each data byte goes to the current page slot. Only the low log2(PAGE_BYTES) address bits advance, wrapping inside the page, so later bytes overwrite earlier ones.
- R7: A commit writes only the page slots that received data. The other bytes of the page keep their old contents.
- R8: No cycle starts if the select rises while `rx_partial` is high, or if the select rises before the first complete data byte.
- R9: `busy` stays high for exactly PAGE_BYTES+PROG_CYCLES clocks after the clock that samples the releasing select. While it is high, every instruction except status read is ignored.
- R10: The write-enable latch clears when a programming cycle completes.
- R11: A status write with the latch set takes bits 7, 3 and 2 of its data byte into `guard_bits` {7,3,2} on a clean release and runs a programming cycle. With the latch clear it has no effect.
- R12: `tx_oe` is low from the first clock that samples the select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Synchronous frame select, active low |
| rx_valid | input | 1 | One-cycle strobe: a complete receive byte is present |
| rx_byte | input | 8 | Received byte |
| rx_partial | input | 1 | Shifter holds an incomplete byte |
| tx_byte | output | 8 | Byte offered to the transmit shifter |
| tx_oe | output | 1 | Transmit output enabled (low means high impedance) |
| mem_raddr | output | ADDR_W | Array read address |
| mem_rdata | input | 8 | Array read data, combinational from mem_raddr |
| mem_we | output | 1 | Array write strobe |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| guard_bits | output | 3 | {pin-protect enable, block protect 1, block protect 0} |
| busy | output | 1 | Programming cycle in progress |

## Verification
A table of instruction bytes covers each command with bit 3 both clear and set, plus bytes with a non-zero upper nibble and unused low codes. Each entry is checked through the output enable and the latch bit, which separates correct decoding from a decoder that looks at too few bits. Reads starting near the top of the array show whether upper address bits are masked and whether the address wraps. A write that starts two slots below the page end, and a 33-byte write, separate in-page wrap from carry into the page number, and show that untouched slots survive. Releases with a half byte, with no data, and during busy separate commit, abort and ignore.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    OP_SET_WEL,
    OP_CLR_WEL,
    OP_STAT_RD,
    OP_STAT_WR,
    OP_ARR_RD,
    OP_ARR_WR,
    OP_INVALID
  } op_kind_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_READ,
    ST_WRITE,
    ST_STAT_OUT,
    ST_STAT_IN,
    ST_STAT_HELD,
    ST_DISCARD
  } eng_state_t;

endpackage

// File: rtl/spi_op_decode.sv
module spi_op_decode
  import spi_mem_pkg::*;
(
  input  logic [7:0] op_byte,
  output op_kind_t   op_kind
);

  always_comb begin
    op_kind = OP_INVALID;
    if (op_byte[7:4] == 4'h0) begin
      unique case (op_byte[2:0])
        3'b110:  op_kind = OP_SET_WEL;
        3'b100:  op_kind = OP_CLR_WEL;
        3'b101:  op_kind = OP_STAT_RD;
        3'b001:  op_kind = OP_STAT_WR;
        3'b011:  op_kind = OP_ARR_RD;
        3'b010:  op_kind = OP_ARR_WR;
        default: op_kind = OP_INVALID;
      endcase
    end
  end

endmodule

// File: rtl/spi_page_buf.sv
module spi_page_buf #(
  parameter int PAGE_BYTES = 32,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_slot,
  input  logic [7:0]    wr_data,
  input  logic [PW-1:0] rd_slot,
  output logic [7:0]    rd_data,
  output logic          rd_used
);

  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] used_q;
  logic [PAGE_BYTES-1:0] used_d;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == PW'(g));

    always_ff @(posedge clk) begin
      if (hit) begin
        slot_q[g] <= wr_data;
      end
    end

    always_comb begin
      used_d[g] = used_q[g];
      if (clr) begin
        used_d[g] = 1'b0;
      end else if (hit) begin
        used_d[g] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else begin
      used_q <= used_d;
    end
  end

  assign rd_data = slot_q[rd_slot];
  assign rd_used = used_q[rd_slot];

  // R6: a slot that takes a byte is marked as filled on the next cycle
  a_r6_slot_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> used_q[$past(wr_slot)]);

endmodule

// File: rtl/spi_prog_timer.sv
module spi_prog_timer #(
  parameter int TOTAL = 64,
  localparam int CW = $clog2(TOTAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          done
);

  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

  logic          busy_d;
  logic [CW-1:0] cnt_d;

  assign done = busy && (cnt == LAST);

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy) begin
      if (done) begin
        busy_d = 1'b0;
      end
      cnt_d = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      busy <= busy_d;
      cnt  <= cnt_d;
    end
  end

  // R9: the engine never relaunches a cycle that is still running
  a_r9_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R9: the count stays inside the cycle length while busy
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST));

endmodule

// File: rtl/spi_mem_cmd_engine.sv
module spi_mem_cmd_engine
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_partial,
  output logic [7:0]        tx_byte,
  output logic              tx_oe,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [2:0]        guard_bits,
  output logic              busy
);

  localparam int PW    = $clog2(PAGE_BYTES);
  localparam int TOTAL = PAGE_BYTES + PROG_CYCLES;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int HW    = ADDR_W - PW;

  eng_state_t        state_q, state_d;
  logic              cs_q;
  logic              wel_q, wel_d;
  logic [2:0]        guard_q, guard_d;
  logic [2:0]        pend_q, pend_d;
  logic [7:0]        ahi_q, ahi_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [HW-1:0]     page_q, page_d;
  logic [PW-1:0]     slot_q, slot_d;
  logic              got_q, got_d;
  logic              iswr_q, iswr_d;
  logic              cpage_q, cpage_d;

  logic              cs_fall, cs_rise;
  logic              start, done;
  logic [CW-1:0]     cnt;
  logic              buf_clr, buf_wr;
  logic [7:0]        buf_rdata;
  logic              buf_used;
  logic [15:0]       full_addr;
  op_kind_t          op_kind;

  spi_op_decode u_dec (
    .op_byte (rx_byte),
    .op_kind (op_kind)
  );

  spi_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (buf_clr),
    .wr_en   (buf_wr),
    .wr_slot (slot_q),
    .wr_data (rx_byte),
    .rd_slot (cnt[PW-1:0]),
    .rd_data (buf_rdata),
    .rd_used (buf_used)
  );

  spi_prog_timer #(.TOTAL(TOTAL)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .cnt   (cnt),
    .done  (done)
  );

  assign cs_fall   = cs_q && !cs_n;
  assign cs_rise   = !cs_q && cs_n;
  assign full_addr = {ahi_q, rx_byte};

  always_comb begin
    state_d = state_q;
    wel_d   = wel_q;
    guard_d = guard_q;
    pend_d  = pend_q;
    ahi_d   = ahi_q;
    addr_d  = addr_q;
    page_d  = page_q;
    slot_d  = slot_q;
    got_d   = got_q;
    iswr_d  = iswr_q;
    cpage_d = cpage_q;
    start   = 1'b0;
    buf_clr = 1'b0;
    buf_wr  = 1'b0;

    if (cs_rise) begin
      state_d = ST_IDLE;
      if (!rx_partial && !busy) begin
        if (state_q == ST_WRITE && got_q) begin
          start   = 1'b1;
          cpage_d = 1'b1;
        end else if (state_q == ST_STAT_HELD) begin
          start   = 1'b1;
          cpage_d = 1'b0;
          guard_d = pend_q;
        end
      end
    end else if (cs_fall) begin
      state_d = ST_OPCODE;
    end else if (rx_valid && !cs_n) begin
      unique case (state_q)
        ST_OPCODE: begin
          state_d = ST_DISCARD;
          if (!busy || op_kind == OP_STAT_RD) begin
            unique case (op_kind)
              OP_SET_WEL: wel_d = 1'b1;
              OP_CLR_WEL: wel_d = 1'b0;
              OP_STAT_RD: state_d = ST_STAT_OUT;
              OP_STAT_WR: if (wel_q) state_d = ST_STAT_IN;
              OP_ARR_RD: begin
                iswr_d  = 1'b0;
                state_d = ST_ADDR_HI;
              end
              OP_ARR_WR: if (wel_q) begin
                iswr_d  = 1'b1;
                state_d = ST_ADDR_HI;
              end
              default: state_d = ST_DISCARD;
            endcase
          end
        end
        ST_ADDR_HI: begin
          ahi_d   = rx_byte;
          state_d = ST_ADDR_LO;
        end
        ST_ADDR_LO: begin
          addr_d = full_addr[ADDR_W-1:0];
          if (iswr_q) begin
            page_d  = full_addr[ADDR_W-1:PW];
            slot_d  = full_addr[PW-1:0];
            got_d   = 1'b0;
            buf_clr = 1'b1;
            state_d = ST_WRITE;
          end else begin
            state_d = ST_READ;
          end
        end
        ST_READ: addr_d = addr_q + ADDR_W'(1);
        ST_WRITE: begin
          buf_wr = 1'b1;
          slot_d = slot_q + PW'(1);
          got_d  = 1'b1;
        end
        ST_STAT_IN: begin
          pend_d  = {rx_byte[7], rx_byte[3:2]};
          state_d = ST_STAT_HELD;
        end
        default: state_d = state_q;
      endcase
    end

    if (done) begin
      wel_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      wel_q   <= 1'b0;
      guard_q <= '0;
      pend_q  <= '0;
      ahi_q   <= '0;
      addr_q  <= '0;
      page_q  <= '0;
      slot_q  <= '0;
      got_q   <= 1'b0;
      iswr_q  <= 1'b0;
      cpage_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_n;
      wel_q   <= wel_d;
      guard_q <= guard_d;
      pend_q  <= pend_d;
      ahi_q   <= ahi_d;
      addr_q  <= addr_d;
      page_q  <= page_d;
      slot_q  <= slot_d;
      got_q   <= got_d;
      iswr_q  <= iswr_d;
      cpage_q <= cpage_d;
    end
  end

  assign tx_oe      = (state_q == ST_READ) || (state_q == ST_STAT_OUT);
  assign tx_byte    = (state_q == ST_STAT_OUT)
                    ? (busy ? 8'hFF : {guard_q[2], 3'b000, guard_q[1:0], wel_q, 1'b0})
                    : mem_rdata;
  assign mem_raddr  = addr_q;
  assign mem_we     = busy && cpage_q && (cnt < CW'(PAGE_BYTES)) && buf_used;
  assign mem_waddr  = {page_q, cnt[PW-1:0]};
  assign mem_wdata  = buf_rdata;
  assign guard_bits = guard_q;

  // R12: output disabled once the select has been seen high
  a_r12_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !tx_oe);

  // R8: a release with a half byte never launches a cycle
  a_r8_partial_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && rx_partial && !busy) |=> !busy);

  // R9: no array access is under way while a cycle runs
  a_r9_busy_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state_q != ST_WRITE && state_q != ST_READ));

  // R10: the latch is clear after a cycle finishes
  a_r10_wel_drops: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wel_q);

endmodule

// File: tb/spi_mem_cmd_engine_tb.sv
module spi_mem_cmd_engine_tb_top;

  localparam int ADDR_W = 10;
  localparam int PAGE   = 32;
  localparam int PROG   = 40;
  localparam int TOTAL  = PAGE + PROG;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs_n;
  logic              rx_valid;
  logic [7:0]        rx_byte;
  logic              rx_partial;
  logic [7:0]        tx_byte;
  logic              tx_oe;
  logic [ADDR_W-1:0] mem_raddr;
  logic [7:0]        mem_rdata;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;
  logic [2:0]        guard_bits;
  logic              busy;

  logic [7:0] mem [DEPTH];
  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  spi_mem_cmd_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_partial(rx_partial), .tx_byte(tx_byte), .tx_oe(tx_oe), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .guard_bits(guard_bits), .busy(busy)
  );

  assign mem_rdata = mem[mem_raddr];
  always @(posedge clk) if (mem_we) mem[mem_waddr] <= mem_wdata;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7) + 3);
  endfunction

  // {opcode, tx_oe after opcode, latch bit afterwards}
  localparam logic [9:0] VEC [12] = '{
    {8'h05, 1'b1, 1'b0}, {8'h0D, 1'b1, 1'b0}, {8'h0E, 1'b0, 1'b1},
    {8'h04, 1'b0, 1'b0}, {8'h06, 1'b0, 1'b1}, {8'h14, 1'b0, 1'b1},
    {8'h0C, 1'b0, 1'b0}, {8'h86, 1'b0, 1'b0}, {8'h07, 1'b0, 1'b0},
    {8'h06, 1'b0, 1'b1}, {8'h00, 1'b0, 1'b1}, {8'h0C, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1; tick(); rx_valid = 1'b0; tick();
  endtask

  task automatic cs_go();
    cs_n = 1'b0; tick();
  endtask

  task automatic cs_stop(input logic part);
    rx_partial = part; cs_n = 1'b1; tick(); rx_partial = 1'b0;
  endtask

  task automatic cmd1(input logic [7:0] op);
    cs_go(); send(op); cs_stop(1'b0); tick();
  endtask

  task automatic rdsr(output logic [7:0] sb);
    cs_go(); send(8'h05); sb = tx_byte; cs_stop(1'b0); tick();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100000) begin n++; tick(); end
  endtask

  task automatic rd_check(input logic [15:0] a, input int n,
                          input logic [7:0] e0, e1, e2, input string tag);
    logic [7:0] ex [3];
    ex[0] = e0; ex[1] = e1; ex[2] = e2;
    cs_go(); send(8'h03); send(a[15:8]); send(a[7:0]);
    for (int k = 0; k < n; k++) begin
      check(tag, tx_byte, ex[k]);
      send(8'h00);
    end
    cs_stop(1'b0);
    check("R12 oe low after release", tx_oe, 0);
    tick();
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] sb;
    int n;
    rst_n = 1'b0; cs_n = 1'b1; rx_valid = 1'b0; rx_byte = '0; rx_partial = 1'b0;
    for (int i = 0; i < DEPTH; i++) mem[i] = pat(i);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("reset tx_oe", tx_oe, 0);
    check("reset busy", busy, 0);
    check("reset mem_we", mem_we, 0);
    check("reset guard_bits", guard_bits, 0);

    // R1 R2 R3: decode table
    for (int v = 0; v < 12; v++) begin
      cs_go(); send(VEC[v][9:2]);
      check($sformatf("R1 oe op %02h", VEC[v][9:2]), tx_oe, VEC[v][1]);
      send(8'h00);
      check($sformatf("R1 oe held op %02h", VEC[v][9:2]), tx_oe, VEC[v][1]);
      cs_stop(1'b0); tick();
      rdsr(sb);
      check($sformatf("R2 latch after op %02h", VEC[v][9:2]), sb, VEC[v][0] ? 8'h02 : 8'h00);
    end

    // R4: upper bits ignored, increment, top wrap
    rd_check(16'hFC03, 3, pat(3), pat(4), pat(5), "R4 read masked addr");
    rd_check(16'h03FE, 3, pat(16'h3FE), pat(16'h3FF), pat(0), "R4 read wrap");

    // R5: write without latch
    cs_go(); send(8'h02); send(8'h00); send(8'h10); send(8'hAA); cs_stop(1'b0);
    check("R5 no cycle without latch", busy, 0);
    tick();
    rd_check(16'h0010, 1, pat(16'h10), 0, 0, "R5 array unchanged");

    // R6 R7 R9 R3 R10: page wrap write
    cmd1(8'h06);
    cs_go(); send(8'h02); send(8'h00); send(8'h5E);
    send(8'hA1); send(8'hA2); send(8'hA3);
    cs_stop(1'b0);
    check("R9 busy after clean release", busy, 1);
    cs_go(); send(8'h03); send(8'h00); send(8'h5E);
    check("R9 read ignored while busy", tx_oe, 0);
    cs_stop(1'b0); tick();
    cs_go(); send(8'h05);
    check("R3 status all ones while busy", tx_byte, 8'hFF);
    check("R3 status drives output", tx_oe, 1);
    cs_stop(1'b0); tick();
    wait_idle(n);
    rdsr(sb);
    check("R10 latch cleared after cycle", sb, 8'h00);
    rd_check(16'h005E, 2, 8'hA1, 8'hA2, 0, "R6 page bytes");
    rd_check(16'h0040, 2, 8'hA3, pat(16'h41), 0, "R7 wrap slot and untouched slot");

    // R9: cycle length
    cmd1(8'h06);
    cs_go(); send(8'h02); send(8'h02); send(8'h00); send(8'h11); cs_stop(1'b0);
    wait_idle(n);
    check("R9 busy length", n, TOTAL);
    rd_check(16'h0200, 1, 8'h11, 0, 0, "R7 single byte committed");

    // R6: 33 bytes overwrite slot 0
    cmd1(8'h06);
    cs_go(); send(8'h02); send(8'h01); send(8'h00);
    for (int k = 0; k < 33; k++) send(8'(8'hC0 + k));
    cs_stop(1'b0);
    wait_idle(n);
    rd_check(16'h0100, 2, 8'hE0, 8'hC1, 0, "R6 overwrite in page");
    rd_check(16'h011F, 2, 8'hDF, pat(16'h120), 0, "R6 no carry to next page");

    // R8: partial release and empty write
    cmd1(8'h06);
    cs_go(); send(8'h02); send(8'h03); send(8'h00); send(8'h55); send(8'h66);
    cs_stop(1'b1);
    check("R8 no cycle on half byte", busy, 0);
    tick();
    rd_check(16'h0300, 1, pat(16'h300), 0, 0, "R8 aborted write left array");
    cs_go(); send(8'h02); send(8'h03); send(8'h00); cs_stop(1'b0);
    check("R8 no cycle without data", busy, 0);
    tick();
    rdsr(sb);
    check("R2 latch kept after abort", sb, 8'h02);

    // R11: status write
    cmd1(8'h04);
    cs_go(); send(8'h01); send(8'h8C); cs_stop(1'b0);
    check("R11 no cycle without latch", busy, 0);
    tick();
    check("R11 guard unchanged", guard_bits, 0);
    cmd1(8'h06);
    cs_go(); send(8'h01); send(8'h8C); cs_stop(1'b0);
    check("R11 status write runs cycle", busy, 1);
    wait_idle(n);
    check("R11 guard bits stored", guard_bits, 3'b111);
    rdsr(sb);
    check("R3 status layout", sb, 8'h8C);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule